// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM controller has to spend a command slot on refresh. A free-running interval timer, sized from the clock period parameter, marks each average refresh interval of 15.6 µs. Each mark adds one to a count of owed refreshes. The scheduler does not ask for a refresh the moment one is owed. It lets refreshes pile up to a deferral threshold and then asks for them back to back until the debt is cleared. This leaves long quiet stretches for read and write traffic. The owed count can never exceed eight. When it reaches eight, the request is raised as urgent, and the arbiter must then put it ahead of pending reads and writes.

The arbiter answers a request with a one-cycle grant, on the cycle it issues the command. After each granted auto-refresh, the scheduler holds off further commands for the refresh cycle time, converted to clocks by rounding up. The controller can also ask to enter self-refresh. The scheduler then raises an entry request in place of any auto-refresh request. Once that is granted, it drops the clock-enable output and discards the owed count, because the device refreshes itself in that state. When the self-refresh request falls, clock enable rises at once. All commands stay blocked until the refresh cycle time has passed, so clock enable is always high at least one cycle before the next command. Closing open banks before a refresh is left to the command controller.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is high and right after it, `ref_req`, `ref_urgent`, `sre_req`, `sr_active` and `cmd_block` are 0 and `cke` is 1.
- R2: In normal operation one refresh becomes owed every REFI_CYC = ceil(REFI_PS / CLK_PERIOD_PS) cycles (780 with defaults). The first one becomes owed on the REFI_CYC-th rising edge after reset is released.
- R3: `ref_req` stays low while fewer than DEFER_THR (default 4) refreshes are owed and no drain is in progress. It rises on the edge where the owed count reaches DEFER_THR, and it then stays high until it is granted.
- R4: Once a drain has started, `ref_req` is raised again after every recovery period, even after the count falls below DEFER_THR, until the owed count reaches zero.
- R5: The owed count saturates at MAX_OWED (default 8). A further interval mark at the cap is dropped, so a full drain from saturation takes exactly MAX_OWED grants. `ref_urgent` is high exactly while `ref_req` is high with MAX_OWED refreshes owed.
- R6: A grant with `ref_req` high is one auto-refresh. From the edge that samples it, `cmd_block` is high and `ref_req` is low for exactly TRFC_CYC = ceil(TRFC_PS / CLK_PERIOD_PS) cycles (4 with defaults).
- R7: A grant while neither `ref_req` nor `sre_req` is high has no effect. It does not block commands and it does not reduce the owed count.
- R8: While `sr_req` is high in normal operation and no recovery is running, `sre_req` is high and `ref_req` is low. A grant of `sre_req` drives `cke` to 0 and `sr_active` and `cmd_block` to 1, and clears the owed count.
- R9: When `sr_req` falls in self-refresh, `cke` rises on the next edge. `cmd_block` and `sr_active` stay high for TRFC_CYC cycles counted from that edge. The interval timer then restarts from zero, so the DEFER_THR-th refresh becomes owed DEFER_THR×REFI_CYC cycles after recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_gnt | input | 1 | One-cycle grant from the command arbiter, given in the cycle it issues the requested command |
| sr_req | input | 1 | Level request to be in self-refresh |
| ref_req | output | 1 | Auto-refresh request to the arbiter |
| ref_urgent | output | 1 | Refresh debt at its cap; the arbiter must put refresh ahead of reads and writes |
| sre_req | output | 1 | Self-refresh entry request to the arbiter |
| cke | output | 1 | Clock enable for the device |
| sr_active | output | 1 | High from self-refresh entry until exit recovery ends |
| cmd_block | output | 1 | No command may be issued while high |

## Verification
The hardest state to reach is a saturated debt. A dropped interval mark must be shown to be lost, not merely late. The bench withholds every grant for more than nine intervals, which lets a ninth mark arrive at the cap. It then grants each request as it appears and counts exactly eight refreshes before the request stays low. The stray-grant case and the timer restart after self-refresh exit are checked by cycle-exact timing. The bench predicts the edge on which `ref_req` must rise from the reset or exit edge, and it samples one cycle before and on that edge.

// File: rtl/sr_sched_pkg.sv
package sr_sched_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_EXIT = 2'd2
  } sched_state_t;

  // ceiling division used to turn picosecond timings into clock counts
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sr_interval_timer.sv
module sr_interval_timer #(
  parameter int PERIOD = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter stays inside its period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);

endmodule

// File: rtl/sr_owed_ctr.sv
module sr_owed_ctr #(
  parameter int MAX_OWED = 8,
  localparam int W = $clog2(MAX_OWED + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         take,
  input  logic         clr,
  output logic [W-1:0] owed_q,
  output logic [W-1:0] owed_d
);
  localparam logic [W-1:0] CAP = W'(MAX_OWED);

  always_comb begin
    owed_d = owed_q;
    if (clr) begin
      owed_d = '0;
    end else if (tick && !take) begin
      if (owed_q != CAP) owed_d = owed_q + 1'b1;
    end else if (take && !tick) begin
      if (owed_q != '0) owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_d;
  end

  // R5: debt never passes the cap
  p_owed_cap_r5: assert property (@(posedge clk) disable iff (rst) owed_q <= CAP);
  // R7: a refresh is only taken when one is owed
  p_take_nonzero_r7: assert property (@(posedge clk) disable iff (rst) take |-> owed_q != '0);

endmodule

// File: rtl/sr_recov_timer.sv
module sr_recov_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy_d
);
  localparam int W = $clog2(CYC + 1);
  localparam logic [W-1:0] LOADV = W'(CYC);

  logic [W-1:0] rem_q;
  logic [W-1:0] rem_d;

  always_comb begin
    if (load)              rem_d = LOADV;
    else if (rem_q != '0)  rem_d = rem_q - 1'b1;
    else                   rem_d = '0;
  end

  assign busy_d = (rem_d != '0);

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_d;
  end

  // R6: remaining count never exceeds the recovery length
  p_rem_range_r6: assert property (@(posedge clk) disable iff (rst) rem_q <= LOADV);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sr_sched_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int REFI_PS       = 15600000,
  parameter int TRFC_PS       = 67500,
  parameter int DEFER_THR     = 4,
  parameter int MAX_OWED      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arb_gnt,
  input  logic sr_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic sre_req,
  output logic cke,
  output logic sr_active,
  output logic cmd_block
);
  localparam int REFI_CYC = cdiv(REFI_PS, CLK_PERIOD_PS);
  localparam int TRFC_CYC = (cdiv(TRFC_PS, CLK_PERIOD_PS) < 1) ? 1 : cdiv(TRFC_PS, CLK_PERIOD_PS);
  localparam int OWED_W   = $clog2(MAX_OWED + 1);
  localparam logic [OWED_W-1:0] DEFER_V = OWED_W'(DEFER_THR);
  localparam logic [OWED_W-1:0] CAP_V   = OWED_W'(MAX_OWED);

  sched_state_t state_q, state_d;
  logic ref_req_q, ref_urgent_q, sre_req_q, cke_q, sr_active_q, cmd_block_q, drain_q;
  logic ref_req_d, drain_d, req_ok;
  logic gnt_ref, gnt_sre, exit_start, tick, busy_d;
  logic [OWED_W-1:0] owed_q, owed_d;

  assign gnt_ref    = arb_gnt && ref_req_q;
  assign gnt_sre    = arb_gnt && sre_req_q;
  assign exit_start = (state_q == ST_SELF) && !sr_req;

  sr_interval_timer #(.PERIOD(REFI_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_RUN),
    .tick (tick)
  );

  sr_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .take   (gnt_ref),
    .clr    (gnt_sre),
    .owed_q (owed_q),
    .owed_d (owed_d)
  );

  sr_recov_timer #(.CYC(TRFC_CYC)) u_rec (
    .clk    (clk),
    .rst    (rst),
    .load   (gnt_ref || exit_start),
    .busy_d (busy_d)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (gnt_sre)    state_d = ST_SELF;
      ST_SELF: if (exit_start) state_d = ST_EXIT;
      ST_EXIT: if (!busy_d)    state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  assign drain_d   = (state_d == ST_RUN) &&
                     ((owed_d >= DEFER_V) || (drain_q && owed_d != '0));
  assign req_ok    = (state_d == ST_RUN) && !busy_d;
  assign ref_req_d = req_ok && !sr_req && drain_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      drain_q      <= 1'b0;
      ref_req_q    <= 1'b0;
      ref_urgent_q <= 1'b0;
      sre_req_q    <= 1'b0;
      cke_q        <= 1'b1;
      sr_active_q  <= 1'b0;
      cmd_block_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      drain_q      <= drain_d;
      ref_req_q    <= ref_req_d;
      ref_urgent_q <= ref_req_d && (owed_d == CAP_V);
      sre_req_q    <= req_ok && sr_req;
      cke_q        <= (state_d != ST_SELF);
      sr_active_q  <= (state_d != ST_RUN);
      cmd_block_q  <= (state_d != ST_RUN) || busy_d;
    end
  end

  assign ref_req    = ref_req_q;
  assign ref_urgent = ref_urgent_q;
  assign sre_req    = sre_req_q;
  assign cke        = cke_q;
  assign sr_active  = sr_active_q;
  assign cmd_block  = cmd_block_q;

  // R8: only one kind of request at a time
  p_req_excl_r8: assert property (@(posedge clk) disable iff (rst) !(ref_req_q && sre_req_q));
  // R5: urgency only accompanies a live request
  p_urgent_req_r5: assert property (@(posedge clk) disable iff (rst) ref_urgent_q |-> ref_req_q);
  // R6: a granted refresh opens a blocked window
  p_after_ref_r6: assert property (@(posedge clk) disable iff (rst)
    (arb_gnt && ref_req_q) |=> (cmd_block_q && !ref_req_q));
  // R8: nothing is requested while the clock is disabled
  p_self_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (cmd_block_q && sr_active_q && !ref_req_q && !sre_req_q));
  // R9: clock enable rises while commands are still held back
  p_cke_lead_r9: assert property (@(posedge clk) disable iff (rst) $rose(cke_q) |-> cmd_block_q);
  // R7: an unrequested grant does not start a blocked window
  p_gnt_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (arb_gnt && !ref_req_q && !sre_req_q && !cmd_block_q && !sr_req && state_q == ST_RUN && !tick)
    |=> !cmd_block_q);

endmodule

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  localparam int TRFC = 4;
  localparam int REFI = 780;
  localparam int MAXO = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arb_gnt = 1'b0;
  logic sr_req = 1'b0;
  logic ref_req, ref_urgent, sre_req, cke, sr_active, cmd_block;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sdram_refresh_sched u_sdram_refresh_sched (
    .clk(clk), .rst(rst), .arb_gnt(arb_gnt), .sr_req(sr_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .sre_req(sre_req),
    .cke(cke), .sr_active(sr_active), .cmd_block(cmd_block)
  );

  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cyc %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  // one granted refresh; checks the blocked window length
  task automatic grant_ref();
    int hi = 0;
    @(negedge clk); arb_gnt = 1'b1;
    @(posedge clk); #1; arb_gnt = 1'b0;
    for (int i = 0; i < TRFC; i++) begin
      if (cmd_block && !ref_req) hi++;
      @(posedge clk); #1;
    end
    chk(hi, TRFC, "R6 blocked window");
    chk(cmd_block, 0, "R6 release");
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk({ref_req, ref_urgent, sre_req, sr_active, cmd_block, cke}, 1, "R1 in reset");
    @(negedge clk); rst = 1'b0;
    chk({ref_req, ref_urgent, sre_req, sr_active, cmd_block, cke}, 1, "R1 after release");
  endtask

  task automatic t_defer_urgent();
    wait_cyc(DEFER_EDGE - 1);
    chk(ref_req, 0, "R3 below threshold");
    wait_cyc(DEFER_EDGE);
    chk(ref_req, 1, "R2 R3 threshold reached");
    wait_cyc(MAXO * REFI - 1);
    chk(ref_urgent, 0, "R5 not yet urgent");
    chk(ref_req, 1, "R3 request held");
    wait_cyc(MAXO * REFI);
    chk(ref_urgent, 1, "R5 urgent at cap");
  endtask
  localparam int DEFER_EDGE = 4 * REFI;

  task automatic t_saturate_drain();
    int n = 0;
    wait_cyc((MAXO + 1) * REFI + 10);
    chk(ref_urgent, 1, "R5 still urgent past cap");
    while (ref_req && n < 20) begin
      grant_ref();
      n++;
      if (n == 1) chk(ref_urgent, 0, "R5 urgency cleared");
    end
    chk(n, MAXO, "R4 R5 drain count from saturation");
  endtask

  task automatic t_stray_grant();
    wait_cyc(10 * REFI + 200);
    chk(ref_req, 0, "R7 idle before stray grant");
    @(negedge clk); arb_gnt = 1'b1;
    @(posedge clk); #1; arb_gnt = 1'b0;
    chk(cmd_block, 0, "R7 stray grant blocks nothing");
    wait_cyc(13 * REFI - 1);
    chk(ref_req, 0, "R7 one short of threshold");
    wait_cyc(13 * REFI);
    chk(ref_req, 1, "R7 debt untouched by stray grant");
  endtask

  task automatic t_self_refresh();
    int cx;
    int hi = 0;
    @(negedge clk); sr_req = 1'b1;
    @(posedge clk); #1;
    chk({ref_req, sre_req}, 1, "R8 entry request replaces refresh");
    @(negedge clk); arb_gnt = 1'b1;
    @(posedge clk); #1; arb_gnt = 1'b0;
    chk({cke, sr_active, cmd_block, sre_req}, 6, "R8 entered self-refresh");
    repeat (2000) @(posedge clk);
    #1;
    chk({cke, ref_req}, 0, "R8 quiet in self-refresh");
    @(negedge clk); sr_req = 1'b0;
    @(posedge clk); #1;
    cx = cyc;
    chk(cke, 1, "R9 cke rises at exit");
    for (int i = 0; i < TRFC; i++) begin
      if (cmd_block && sr_active) hi++;
      @(posedge clk); #1;
    end
    chk(hi, TRFC, "R9 exit recovery length");
    chk({cmd_block, sr_active}, 0, "R9 released after recovery");
    wait_cyc(cx + TRFC + DEFER_EDGE - 1);
    chk(ref_req, 0, "R8 R9 debt cleared and timer restarted");
    wait_cyc(cx + TRFC + DEFER_EDGE);
    chk(ref_req, 1, "R9 threshold after restart");
  endtask

  initial begin
    t_reset();
    t_defer_urgent();
    t_saturate_drain();
    t_stray_grant();
    t_self_refresh();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule